// File: doc/BRIEF.md
# Nearest-Level Submodule Insertion Sequencer

This block drives one phase arm of a cascaded-bridge converter whose submodule DC links carry slowly varying, unequal voltages. On every sample it takes a signed voltage reference, the measured voltage of each submodule and a ranked slot list of submodule indices. From these it decides which submodules are inserted and which are bypassed, and which polarity the arm produces. Only the magnitude of the reference sets the number of inserted submodules. Its sign only sets the polarity output.

Switching thresholds come from running sums of the real voltages of the ranked submodules. The threshold of each slot is the voltage already stacked in the slots before it, plus half of that slot's own voltage. The count of inserted modules therefore follows nearest-level rounding even when the modules differ. A release mode, taken together with the slot list, selects how modules leave the stack.

- In the stacked (last-in, first-out) mode, the first module inserted in a half cycle stays on longest.
- In the balanced mode, a detected crest of the reference reverses the release order, so modules leave in the order they entered. This evens out the on-time between the first and the last modules.

The slot list, the voltages and the mode are taken only at a polarity change while the arm is empty, so they never change within a half cycle.

Top module: `nl_arm_sequencer`

## Requirements
- R1: While reset is held, and in the cycle after its release, all insert bits, the polarity output and the saturation flag are 0.
- R2: The slot list, voltages and mode are captured only in a cycle where the inserted count is 0 and either no capture has happened since reset or the sign bit of the reference differs from the registered polarity. A capture cycle leaves the count at 0. Changes at other times have no effect on the outputs until the next capture.
- R3: The threshold of slot k is the sum of the captured voltages of slots 0..k-1 plus floor(half of slot k's voltage). The target count is the number of slots whose threshold is strictly below the reference magnitude.
- R4: The inserted count moves by at most one per cycle toward the target. Outputs reflect a sample one clock after it is presented.
- R5: The polarity output is 1 when the registered reference was negative. Levels depend only on the absolute value of the reference.
- R6: In stacked mode (mode input 0), the inserted modules are those named in slots 0..count-1.
- R7: In balanced mode (mode input 1), a crest is detected when the count is non-zero, no crest has been seen yet in this half cycle, and the running maximum magnitude exceeds the present magnitude by more than the hysteresis input. The count P at that cycle is held. After that, while count < P, the inserted modules are slots P-count..P-1, so the earliest inserted module is released first.
- R8: Whenever the count is 0, the crest state is cleared and the running maximum restarts from the present magnitude.
- R9: The saturation flag is registered as 1 when the reference magnitude exceeds the sum of all captured voltages.
- R10: A change of the mode input takes effect only at the next capture described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | RW | Signed voltage reference, same LSB as the module voltages |
| vsm_i | input | N_SM*VW | Unsigned measured voltage per submodule, module m at bits m*VW |
| order_i | input | N_SM*IDXW | Slot list: slot k holds a module index at bits k*IDXW |
| mode_i | input | 1 | Release mode: 0 stacked, 1 balanced |
| hyst_i | input | RW | Crest-detection hysteresis, unsigned |
| ins_o | output | N_SM | Per-module insert (1) or bypass (0) |
| neg_o | output | 1 | Arm polarity: 1 negative |
| sat_o | output | 1 | Reference beyond the full stacked voltage |

## Verification
Every output is registered once from the sampled inputs, so each result is due exactly one clock after its sample. The captured slot list and thresholds affect the count from the sample after the capture. The bench drives inputs on the falling edge. Its behavioural model advances on the rising edge, and the bench compares all three outputs on the next falling edge. A step in the reference is expected to walk the count one slot per clock, and each step is compared in its own cycle.

// File: rtl/nl_seq_pkg.sv
// Shared definitions for the arm insertion sequencer.
// Assumes: mode bit 0 selects stacked release, 1 selects balanced release.
package nl_seq_pkg;
    typedef enum logic {
        REL_STACKED  = 1'b0,
        REL_BALANCED = 1'b1
    } rel_mode_e;
endpackage

// File: rtl/nl_thresholds.sv
// Computes per-slot switching thresholds from a slot list and module voltages.
// Assumes: every slot holds a valid module index; sums cannot overflow SW bits.
module nl_thresholds #(
    parameter int N_SM = 6,
    parameter int VW   = 12,
    parameter int IDXW = 3,
    parameter int SW   = 15
) (
    input  logic [N_SM*VW-1:0]   volts,
    input  logic [N_SM*IDXW-1:0] order,
    output logic [N_SM*SW-1:0]   thr,
    output logic [SW-1:0]        total
);
    // Walk the slots, accumulating voltage and placing each midpoint.
    always_comb begin
        logic [SW-1:0] acc;
        logic [VW-1:0] vk;
        acc = '0;
        thr = '0;
        for (int k = 0; k < N_SM; k++) begin
            vk = '0;
            for (int j = 0; j < N_SM; j++) begin
                if (order[k*IDXW +: IDXW] == IDXW'(j)) vk = volts[j*VW +: VW];
            end
            thr[k*SW +: SW] = acc + SW'(vk >> 1);
            acc = acc + SW'(vk);
        end
        total = acc;
    end
endmodule

// File: rtl/nl_level_ctrl.sv
// Tracks the inserted count and, in balanced mode, the crest of the reference.
// Assumes: thresholds are non-decreasing across slots; hold forces the count to 0.
module nl_level_ctrl #(
    parameter int N_SM = 6,
    parameter int SW   = 15,
    parameter int CW   = 17,
    parameter int CNTW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     mag,
    input  logic [CW-1:0]     hyst,
    input  logic [N_SM*SW-1:0] thr,
    input  logic              sym,
    input  logic              hold,
    output logic [CNTW-1:0]   cnt_q,
    output logic [CNTW-1:0]   pk_q,
    output logic              peaked_q
);
    logic [CNTW-1:0] tgt;
    logic [CW-1:0]   mx_q;
    logic            crest;

    // Nearest-level target: slots whose midpoint lies below the magnitude.
    always_comb begin
        tgt = '0;
        for (int k = 0; k < N_SM; k++) begin
            if (mag > CW'(thr[k*SW +: SW])) tgt = tgt + 1'b1;
        end
    end

    // Crest: fall from the running maximum beyond the hysteresis.
    assign crest = sym && !peaked_q && (cnt_q != '0) && (mx_q > mag) && ((mx_q - mag) > hyst);

    // Count stepping, running maximum and crest capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            pk_q     <= '0;
            peaked_q <= 1'b0;
            mx_q     <= '0;
        end else begin
            if (hold)            cnt_q <= '0;
            else if (tgt > cnt_q) cnt_q <= cnt_q + 1'b1;
            else if (tgt < cnt_q) cnt_q <= cnt_q - 1'b1;
            if (cnt_q == '0) begin
                peaked_q <= 1'b0;
                mx_q     <= mag;
            end else begin
                if (mag > mx_q) mx_q <= mag;
                if (crest) begin
                    peaked_q <= 1'b1;
                    pk_q     <= cnt_q;
                end
            end
        end
    end
endmodule

// File: rtl/nl_release_map.sv
// Maps the inserted count onto module insert bits through the slot list.
// Assumes: after a crest the active slot window ends at the captured count.
module nl_release_map #(
    parameter int N_SM = 6,
    parameter int IDXW = 3,
    parameter int CNTW = 3
) (
    input  logic [N_SM*IDXW-1:0] ord,
    input  logic [CNTW-1:0]      cnt,
    input  logic [CNTW-1:0]      pk,
    input  logic                 peaked,
    output logic [N_SM-1:0]      ins
);
    logic [CNTW-1:0] lo;
    logic [CNTW:0]   hi;

    // Select the window of slots [lo, hi) and set the bits of their modules.
    always_comb begin
        lo  = (peaked && (cnt < pk)) ? (pk - cnt) : '0;
        hi  = {1'b0, lo} + {1'b0, cnt};
        ins = '0;
        for (int s = 0; s < N_SM; s++) begin
            for (int m = 0; m < N_SM; m++) begin
                if (((CNTW+1)'(s) >= {1'b0, lo}) && ((CNTW+1)'(s) < hi) &&
                    (ord[s*IDXW +: IDXW] == IDXW'(m)))
                    ins[m] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nl_arm_sequencer.sv
// Top of the arm sequencer: magnitude/polarity, capture of slot list, saturation.
// Assumes: ref_i and vsm_i share one LSB; order_i is a permutation of module indices.
module nl_arm_sequencer #(
    parameter int N_SM = 6,
    parameter int VW   = 12,
    parameter int RW   = 16,
    parameter int IDXW = (N_SM > 1) ? $clog2(N_SM) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [RW-1:0]   ref_i,
    input  logic [N_SM*VW-1:0]     vsm_i,
    input  logic [N_SM*IDXW-1:0]   order_i,
    input  logic                   mode_i,
    input  logic [RW-1:0]          hyst_i,
    output logic [N_SM-1:0]        ins_o,
    output logic                   neg_o,
    output logic                   sat_o
);
    import nl_seq_pkg::*;

    localparam int CNTW = $clog2(N_SM + 1);
    localparam int SW   = VW + CNTW;
    localparam int CW   = ((RW > SW) ? RW : SW) + 1;

    logic [RW-1:0]        ref_abs;
    logic [CW-1:0]        mag;
    logic [N_SM*SW-1:0]   thr_in, thr_q;
    logic [SW-1:0]        total_in, total_q;
    logic [N_SM*IDXW-1:0] ord_q;
    logic                 mode_q;
    logic                 loaded_q;
    logic                 neg_q, sat_q;
    logic                 capture;
    logic [CNTW-1:0]      cnt_q, pk_q;
    logic                 peaked_q;

    // Reference magnitude; the most negative code maps to its true size.
    assign ref_abs = ref_i[RW-1] ? RW'(-ref_i) : RW'(ref_i);
    assign mag     = CW'(ref_abs);

    // Capture only with an empty arm at a polarity change, or once after reset.
    assign capture = (cnt_q == '0) && (!loaded_q || (ref_i[RW-1] != neg_q));

    nl_thresholds #(.N_SM(N_SM), .VW(VW), .IDXW(IDXW), .SW(SW)) u_thr (
        .volts (vsm_i),
        .order (order_i),
        .thr   (thr_in),
        .total (total_in)
    );

    // Hold slot list, thresholds, full voltage and mode between captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q    <= '0;
            total_q  <= '0;
            ord_q    <= '0;
            mode_q   <= REL_STACKED;
            loaded_q <= 1'b0;
        end else if (capture) begin
            thr_q    <= thr_in;
            total_q  <= total_in;
            ord_q    <= order_i;
            mode_q   <= mode_i;
            loaded_q <= 1'b1;
        end
    end

    // Register polarity and saturation every sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
            sat_q <= 1'b0;
        end else begin
            neg_q <= ref_i[RW-1];
            sat_q <= mag > CW'(total_q);
        end
    end

    nl_level_ctrl #(.N_SM(N_SM), .SW(SW), .CW(CW), .CNTW(CNTW)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mag      (mag),
        .hyst     (CW'(hyst_i)),
        .thr      (thr_q),
        .sym      (mode_q == REL_BALANCED),
        .hold     (capture),
        .cnt_q    (cnt_q),
        .pk_q     (pk_q),
        .peaked_q (peaked_q)
    );

    nl_release_map #(.N_SM(N_SM), .IDXW(IDXW), .CNTW(CNTW)) u_map (
        .ord    (ord_q),
        .cnt    (cnt_q),
        .pk     (pk_q),
        .peaked (peaked_q),
        .ins    (ins_o)
    );

    assign neg_o = neg_q;
    assign sat_o = sat_q;
endmodule

// File: rtl/nl_arm_sequencer_chk.sv
// Property checker for the arm sequencer, attached by bind below.
// Assumes: slot list entries are valid module indices.
module nl_arm_sequencer_chk #(
    parameter int N_SM = 6,
    parameter int IDXW = 3,
    parameter int CNTW = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_SM-1:0]        ins,
    input logic [N_SM*IDXW-1:0]   ord,
    input logic                   sym,
    input logic [CNTW-1:0]        cnt,
    input logic [CNTW-1:0]        pk,
    input logic                   peaked
);
    a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ins) <= $countones($past(ins)) + 1) &&
        ($countones($past(ins)) <= $countones(ins) + 1));

    a_r2_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ord) |-> ($past(ins) == '0));

    a_r6_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym && (ins != '0)) |-> ins[ord[IDXW-1:0]]);

    a_r7_head_released: assert property (@(posedge clk) disable iff (!rst_n)
        (sym && peaked && (cnt != '0) && (cnt < pk)) |-> !ins[ord[IDXW-1:0]]);

    a_r8_empty_no_crest: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == '0) |-> !peaked);
endmodule

bind nl_arm_sequencer nl_arm_sequencer_chk #(.N_SM(N_SM), .IDXW(IDXW), .CNTW(CNTW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ins    (ins_o),
    .ord    (ord_q),
    .sym    (mode_q),
    .cnt    (cnt_q),
    .pk     (pk_q),
    .peaked (peaked_q)
);

// File: tb/nl_arm_sequencer_test.sv
// Bench: behavioural model stepped on each rising edge, compared on falling edges.
module nl_arm_sequencer_test;
    localparam int N    = 6;
    localparam int VW   = 12;
    localparam int RW   = 16;
    localparam int IDXW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst_n;
    logic signed [RW-1:0] ref_i;
    logic [N*VW-1:0]      vsm_i;
    logic [N*IDXW-1:0]    order_i;
    logic                 mode_i;
    logic [RW-1:0]        hyst_i;
    logic [N-1:0]         ins_o;
    logic                 neg_o, sat_o;

    int  drv_v[N];
    int  drv_ord[N];
    int  drv_ref  = 0;
    int  drv_hyst = 0;
    bit  drv_mode = 0;

    always_comb begin
        for (int m = 0; m < N; m++) begin
            vsm_i[m*VW +: VW]     = VW'(drv_v[m]);
            order_i[m*IDXW +: IDXW] = IDXW'(drv_ord[m]);
        end
    end
    assign ref_i  = RW'(drv_ref);
    assign hyst_i = RW'(drv_hyst);
    assign mode_i = drv_mode;

    nl_arm_sequencer #(.N_SM(N), .VW(VW), .RW(RW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .vsm_i(vsm_i), .order_i(order_i),
        .mode_i(mode_i), .hyst_i(hyst_i), .ins_o(ins_o), .neg_o(neg_o), .sat_o(sat_o)
    );

    // Model state
    int m_v[N], m_ord[N];
    int m_cnt, m_pk, m_mx;
    bit m_peaked, m_neg, m_sat, m_loaded, m_sym;

    int    nchk  = 0;
    int    nfail = 0;
    string req   = "R1";

    // Advance the model with the inputs present at this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pk = 0; m_mx = 0; m_peaked = 0; m_neg = 0; m_sat = 0;
            m_loaded = 0; m_sym = 0;
            for (int m = 0; m < N; m++) begin m_v[m] = 0; m_ord[m] = 0; end
        end else begin
            int mag, tgt, acc, tot, ocnt;
            bit nneg, cap, crest;
            mag  = (drv_ref < 0) ? -drv_ref : drv_ref;
            nneg = drv_ref < 0;
            tgt = 0; acc = 0;
            for (int k = 0; k < N; k++) begin
                if (mag > acc + m_v[m_ord[k]] / 2) tgt++;
                acc += m_v[m_ord[k]];
            end
            tot   = acc;
            ocnt  = m_cnt;
            cap   = (m_cnt == 0) && (!m_loaded || (nneg != m_neg));
            crest = m_sym && !m_peaked && (m_cnt != 0) && (m_mx - mag > drv_hyst);
            if (cap) m_cnt = 0;
            else if (tgt > m_cnt) m_cnt++;
            else if (tgt < m_cnt) m_cnt--;
            if (ocnt == 0) begin
                m_peaked = 0; m_mx = mag;
            end else begin
                if (mag > m_mx) m_mx = mag;
                if (crest) begin m_peaked = 1; m_pk = ocnt; end
            end
            m_sat = mag > tot;
            m_neg = nneg;
            if (cap) begin
                for (int m = 0; m < N; m++) begin m_v[m] = drv_v[m]; m_ord[m] = drv_ord[m]; end
                m_sym = drv_mode; m_loaded = 1;
            end
        end
    end

    function automatic logic [N-1:0] exp_ins();
        logic [N-1:0] e;
        int lo;
        e  = '0;
        lo = (m_peaked && m_cnt < m_pk) ? m_pk - m_cnt : 0;
        for (int s = lo; s < lo + m_cnt; s++) e[m_ord[s]] = 1'b1;
        return e;
    endfunction

    task automatic check();
        logic [N-1:0] e;
        e = exp_ins();
        nchk++;
        if (ins_o !== e || neg_o !== m_neg || sat_o !== m_sat) begin
            nfail++;
            $display("FAIL %s t=%0t ins/neg/sat actual %b/%b/%b expected %b/%b/%b",
                     req, $time, ins_o, neg_o, sat_o, e, m_neg, m_sat);
        end
    endtask

    // One sample per clock: compare, then drive the next reference value.
    task automatic run_sine(int amp, int period, int cycles, int noise);
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            check();
            drv_ref = $rtoi(amp * $sin(2.0 * 3.14159265 * t / period));
            if (noise != 0) drv_ref += ((t * 7) % 5) - 2;
        end
    endtask

    task automatic run_const(int val, int cycles);
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            check();
            drv_ref = val;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        drv_v   = '{1000, 900, 1100, 800, 950, 1050};
        drv_ord = '{0, 1, 2, 3, 4, 5};
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        req = "R1";
        nchk++;
        if (ins_o !== '0 || neg_o !== 1'b0 || sat_o !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset actual %b/%b/%b expected 0/0/0", ins_o, neg_o, sat_o);
        end
        rst_n = 1'b1;
        run_const(0, 3);
        // Stacked release over full cycles, both polarities
        req = "R3/R6";
        run_sine(4000, 240, 480, 0);
        req = "R5";
        run_sine(-3000, 240, 240, 0);
        // Step: count walks one slot per clock, then saturates
        req = "R4/R9";
        run_const(0, 10);
        run_const(6000, 12);
        run_const(0, 12);
        // Balanced release with crest noise; mode taken at a capture
        req = "R7/R8/R10";
        drv_mode = 1'b1;
        drv_hyst = 20;
        drv_ord  = '{3, 1, 5, 0, 2, 4};
        run_sine(5000, 240, 720, 1);
        // Slot list and voltages changed mid half cycle
        req = "R2";
        for (int t = 0; t < 240; t++) begin
            @(negedge clk);
            check();
            if (t == 60) begin
                drv_ord = '{5, 4, 3, 2, 1, 0};
                drv_v   = '{700, 1200, 900, 1000, 800, 1100};
            end
            drv_ref = $rtoi(4500 * $sin(2.0 * 3.14159265 * t / 240));
        end
        run_sine(4500, 240, 240, 0);
        // Hysteresis too large: no crest, behaves as stacked
        req = "R7";
        drv_hyst = 9000;
        run_sine(4000, 240, 240, 1);
        // Saturation with balanced release, then back to stacked
        req = "R9";
        drv_hyst = 20;
        run_sine(7000, 240, 240, 0);
        req = "R10";
        drv_mode = 1'b0;
        run_sine(5000, 240, 480, 1);
        run_const(0, 6);
        finish_run();
    end
endmodule